// File: doc/BRIEF.md
# DSI Packet Header and CRC Generator

This block turns one packet request into the byte stream of a display serial interface packet. A request carries a data type, a virtual channel, a 16-bit word and a packet kind. The block forms the 4-byte packet header and computes its 6-bit error-correcting code over the first 24 header bits. A short packet ends after the header. For a long packet, the 16-bit word is the payload length in bytes, and the header is followed by that many payload bytes and then a 16-bit checksum.

Payload bytes come from one of two sources. In streaming mode, bytes come from an upstream byte port and pass straight through to the output. In fill mode, every payload byte is one fill byte taken from the request. Fill mode produces blanking packets without an upstream source. In both modes the checksum is computed on the fly while the bytes leave the block. Lane distribution, the physical layer and timing calculations belong to other blocks.

Top module: `dsi_pkt_gen`

## Requirements
- R1: Header bytes leave in this order: first `{vc[1:0], dt[5:0]}`, then `req_word[7:0]`, then `req_word[15:8]`, then the ECC byte. This order applies to short and long packets alike.
- R2: For a long packet, header bytes 1 and 2 carry the payload byte count from `req_word`, low byte first, and exactly that many payload bytes follow.
- R3: ECC bit k (k = 0 to 5) is the XOR of the 24 header bits selected by mask k. The masks are 0xF12CB7, 0xF2555B, 0x749A6D, 0xB8E38E, 0xDF03F0 and 0xEFFC00. ECC bits 7:6 are sent as zero. For example, dt=0x05, vc=0 and word=0 give ECC 0x0A.
- R4: The checksum runs over the payload bytes only. It is the reflected CCITT CRC: polynomial 0x8408, LSB first, start value 0xFFFF, no final inversion. The payload "123456789" gives 0x6F91.
- R5: After the payload of a long packet come two checksum bytes, low byte first. `out_last` is high only on the high checksum byte.
- R6: A short packet (`req_long`=0) emits exactly 4 bytes, with `out_last` on the fourth byte and no checksum.
- R7: With `req_fill_en`=1, every payload byte equals `req_fill`. In that mode `pay_ready` stays low, and `pay_valid` and `pay_data` have no effect on the output.
- R8: A long packet with a count of 0 emits 6 bytes: the header, then 0xFF, 0xFF.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values and `out_valid` stays high in the next cycle.
- R10: `req_ready` is high only when no packet is in progress and reset has been released for two clock edges. During reset, `out_valid`, `pay_ready` and `req_ready` are low. A reset in the middle of a packet drops that packet.
- R11: In streaming mode during the payload, `pay_ready` follows `out_ready`, `out_valid` follows `pay_valid`, and `out_data` equals `pay_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Packet request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_dt | input | 6 | Data type |
| req_vc | input | 2 | Virtual channel |
| req_long | input | 1 | 1 = long packet with payload and checksum |
| req_fill_en | input | 1 | 1 = payload made of the fill byte |
| req_word | input | 16 | Payload count (long) or two data bytes (short) |
| req_fill | input | 8 | Fill byte for fill mode |
| pay_valid | input | 1 | Upstream payload byte present |
| pay_ready | output | 1 | Upstream payload byte consumed |
| pay_data | input | 8 | Upstream payload byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the packet |

## Verification
A wrong internal state shows up within one packet as a wrong output byte or as a stream that ends at the wrong byte. A wrong state-machine position or byte index gives a wrong byte count or misplaces `out_last`. A wrong payload countdown gives a wrong packet length. A corrupted checksum register changes both checksum bytes, and that shows only at the very end of a long packet. The bench therefore compares every byte of each packet, the byte count and the position of `out_last`. It does so under several backpressure patterns, to expose states that lose or repeat a byte when the consumer stalls.

// File: rtl/dsi_pkt_pkg.sv
package dsi_pkt_pkg;
  localparam int BYTE_W     = 8;
  localparam int HDR_BYTES  = 4;
  localparam int HDR_W      = HDR_BYTES * BYTE_W;
  localparam int HDR_DATA_W = HDR_W - BYTE_W;
  localparam int ECC_BITS   = 6;
  localparam int DT_W       = 6;
  localparam int VC_W       = 2;
  localparam int WORD_W     = 2 * BYTE_W;
  localparam int CRC_W      = 16;
  localparam int IDX_W      = $clog2(HDR_BYTES);

  localparam logic [HDR_DATA_W-1:0] ECC_MASK [ECC_BITS] = '{
    24'hF12CB7, 24'hF2555B, 24'h749A6D, 24'hB8E38E, 24'hDF03F0, 24'hEFFC00
  };

  localparam logic [CRC_W-1:0] CRC_POLY_REV = 16'h8408;
  localparam logic [CRC_W-1:0] CRC_SEED     = 16'hFFFF;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PAY, ST_CRC} pkt_state_e;

  // One byte of the reflected CRC, least significant bit first.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] r;
    r = c ^ {{(CRC_W-BYTE_W){1'b0}}, b};
    for (int i = 0; i < BYTE_W; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REV) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/dsi_ecc_gen.sv
module dsi_ecc_gen
  import dsi_pkt_pkg::*;
(
  input  logic [HDR_DATA_W-1:0] hdr_bits,
  output logic [BYTE_W-1:0]     ecc_byte
);
  generate
    for (genvar g = 0; g < ECC_BITS; g++) begin : g_par
      assign ecc_byte[g] = ^(hdr_bits & ECC_MASK[g]);
    end
    for (genvar g = ECC_BITS; g < BYTE_W; g++) begin : g_pad
      assign ecc_byte[g] = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/dsi_crc_acc.sv
module dsi_crc_acc
  import dsi_pkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc
);
  logic [CRC_W-1:0] crc_q, crc_d;
  logic             crc_we;

  assign crc_we = clr | en;

  always_comb begin
    crc_d = crc_q;
    if (clr)     crc_d = CRC_SEED;
    else if (en) crc_d = crc_step(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= CRC_SEED;
    else if (crc_we) crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/dsi_pkt_seq.sv
module dsi_pkt_seq
  import dsi_pkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [HDR_W-1:0]  req_hdr,
  input  logic              req_long,
  input  logic              req_fill_en,
  input  logic [BYTE_W-1:0] req_fill,
  input  logic              pay_valid,
  output logic              pay_ready,
  input  logic [BYTE_W-1:0] pay_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last,
  input  logic [CRC_W-1:0]  crc_val,
  output logic              crc_clr,
  output logic              crc_en
);
  pkt_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] left_q, left_d;
  logic [HDR_W-1:0]  hdr_q;
  logic              long_q, fill_en_q;
  logic [BYTE_W-1:0] fill_q;
  logic              load;
  logic [WORD_W-1:0] hdr_count;

  assign hdr_count = hdr_q[BYTE_W +: WORD_W];
  assign req_ready = run && (state_q == ST_IDLE);
  assign load      = req_valid && req_ready;

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    left_d    = left_q;
    out_valid = 1'b0;
    out_data  = '0;
    out_last  = 1'b0;
    pay_ready = 1'b0;
    crc_clr   = 1'b0;
    crc_en    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (load) begin
          state_d = ST_HDR;
          idx_d   = '0;
          crc_clr = 1'b1;
        end
      end
      ST_HDR: begin
        out_valid = 1'b1;
        out_data  = hdr_q[{idx_q, 3'b000} +: BYTE_W];
        out_last  = !long_q && (idx_q == IDX_W'(HDR_BYTES - 1));
        if (out_ready) begin
          if (idx_q == IDX_W'(HDR_BYTES - 1)) begin
            idx_d = '0;
            if (!long_q)                 state_d = ST_IDLE;
            else if (hdr_count == '0)    state_d = ST_CRC;
            else begin
              state_d = ST_PAY;
              left_d  = hdr_count;
            end
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_PAY: begin
        if (fill_en_q) begin
          out_valid = 1'b1;
          out_data  = fill_q;
        end else begin
          out_valid = pay_valid;
          out_data  = pay_data;
          pay_ready = out_ready;
        end
        if (out_valid && out_ready) begin
          crc_en = 1'b1;
          left_d = left_q - 1'b1;
          if (left_q == WORD_W'(1)) begin
            state_d = ST_CRC;
            idx_d   = '0;
          end
        end
      end
      ST_CRC: begin
        out_valid = 1'b1;
        out_data  = idx_q[0] ? crc_val[CRC_W-1:BYTE_W] : crc_val[BYTE_W-1:0];
        out_last  = idx_q[0];
        if (out_ready) begin
          if (idx_q[0]) begin
            state_d = ST_IDLE;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      left_q  <= left_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q     <= '0;
      long_q    <= 1'b0;
      fill_en_q <= 1'b0;
      fill_q    <= '0;
    end else if (load) begin
      hdr_q     <= req_hdr;
      long_q    <= req_long;
      fill_en_q <= req_fill_en;
      fill_q    <= req_fill;
    end
  end
endmodule

// File: rtl/dsi_pkt_gen.sv
module dsi_pkt_gen
  import dsi_pkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DT_W-1:0]   req_dt,
  input  logic [VC_W-1:0]   req_vc,
  input  logic              req_long,
  input  logic              req_fill_en,
  input  logic [WORD_W-1:0] req_word,
  input  logic [BYTE_W-1:0] req_fill,
  input  logic              pay_valid,
  output logic              pay_ready,
  input  logic [BYTE_W-1:0] pay_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last
);
  logic                  rs_meta, rs_sync;
  logic [HDR_DATA_W-1:0] hdr_bits;
  logic [BYTE_W-1:0]     ecc_byte;
  logic [CRC_W-1:0]      crc_val;
  logic                  crc_clr, crc_en;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_sync <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_sync <= rs_meta;
    end
  end

  assign hdr_bits = {req_word, req_vc, req_dt};

  dsi_ecc_gen u_ecc (
    .hdr_bits (hdr_bits),
    .ecc_byte (ecc_byte)
  );

  dsi_crc_acc u_crc (
    .clk   (clk),
    .rst_n (rs_sync),
    .clr   (crc_clr),
    .en    (crc_en),
    .din   (out_data),
    .crc   (crc_val)
  );

  dsi_pkt_seq u_seq (
    .clk         (clk),
    .rst_n       (rs_sync),
    .run         (rs_sync),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_hdr     ({ecc_byte, hdr_bits}),
    .req_long    (req_long),
    .req_fill_en (req_fill_en),
    .req_fill    (req_fill),
    .pay_valid   (pay_valid),
    .pay_ready   (pay_ready),
    .pay_data    (pay_data),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_last    (out_last),
    .crc_val     (crc_val),
    .crc_clr     (crc_clr),
    .crc_en      (crc_en)
  );
endmodule

// File: rtl/dsi_pkt_gen_chk.sv
module dsi_pkt_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_long,
  input logic       req_fill_en,
  input logic       pay_valid,
  input logic       pay_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last
);
  logic [3:0] pos_q;
  logic       long_cap, fill_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      long_cap <= 1'b0;
      fill_cap <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        long_cap <= req_long;
        fill_cap <= req_fill_en;
      end
      if (out_valid && out_ready) begin
        if (out_last)             pos_q <= '0;
        else if (pos_q != 4'hF)   pos_q <= pos_q + 1'b1;
      end
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_ecc_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && pos_q == 4'd3) |-> (out_data[7:6] == 2'b00));

  assert_short_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && pos_q == 4'd3 && !long_cap) |-> out_last);

  assert_long_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last && long_cap) |-> (pos_q >= 4'd5));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!out_valid && pos_q == 4'd0));

  assert_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pay_ready |-> !fill_cap);

  assert_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pay_ready |-> (out_ready && out_valid == pay_valid));
endmodule

bind dsi_pkt_gen dsi_pkt_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_long    (req_long),
  .req_fill_en (req_fill_en),
  .pay_valid   (pay_valid),
  .pay_ready   (pay_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_last    (out_last)
);

// File: tb/tb_dsi_pkt_gen.sv
module tb_dsi_pkt_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_long, req_fill_en;
  logic [5:0]  req_dt;
  logic [1:0]  req_vc;
  logic [15:0] req_word;
  logic [7:0]  req_fill;
  logic        pay_valid, pay_ready;
  logic [7:0]  pay_data;
  logic        out_valid, out_ready, out_last;
  logic [7:0]  out_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dsi_pkt_gen dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_dt(req_dt), .req_vc(req_vc),
    .req_long(req_long), .req_fill_en(req_fill_en), .req_word(req_word), .req_fill(req_fill),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  typedef struct packed {
    logic [5:0]  dt;
    logic [1:0]  vc;
    logic        lng;
    logic        fen;
    logic [15:0] word;
    logic [7:0]  fill;
    logic        src;
    logic [1:0]  bp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{6'h05, 2'd0, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, 2'd0},
    '{6'h15, 2'd3, 1'b0, 1'b0, 16'hA529, 8'h00, 1'b0, 2'd1},
    '{6'h39, 2'd1, 1'b1, 1'b0, 16'd9,    8'h00, 1'b0, 2'd0},
    '{6'h19, 2'd0, 1'b1, 1'b1, 16'd6,    8'h00, 1'b0, 2'd1},
    '{6'h19, 2'd2, 1'b1, 1'b1, 16'd10,   8'hA5, 1'b0, 2'd2},
    '{6'h29, 2'd0, 1'b1, 1'b0, 16'd0,    8'h00, 1'b0, 2'd2},
    '{6'h39, 2'd2, 1'b1, 1'b0, 16'd20,   8'h00, 1'b1, 2'd2},
    '{6'h19, 2'd1, 1'b1, 1'b1, 16'd1,    8'h3C, 1'b0, 2'd0}
  };

  localparam logic [23:0] REF_MASK [6] = '{
    24'hF12CB7, 24'hF2555B, 24'h749A6D, 24'hB8E38E, 24'hDF03F0, 24'hEFFC00
  };

  logic [7:0]  exp_b [0:63];
  logic [7:0]  got_b [0:63];
  logic [15:0] lf = 16'hACE1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] ref_ecc(input logic [23:0] d);
    logic [7:0] e = 8'h00;
    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j < 24; j++) begin
        if (REF_MASK[k][j]) e[k] = e[k] ^ d[j];
      end
    end
    return e;
  endfunction

  function automatic logic [7:0] pay_byte(input logic src, input int i);
    return src ? 8'((i * 37) + 5) : 8'(8'h31 + i);
  endfunction

  // Builds the expected byte list; returns its length.
  function automatic int build_exp(input vec_t v);
    logic [23:0] h;
    logic [15:0] c;
    int          n;
    logic [7:0]  b;
    h = {v.word, v.vc, v.dt};
    exp_b[0] = h[7:0];
    exp_b[1] = h[15:8];
    exp_b[2] = h[23:16];
    exp_b[3] = ref_ecc(h);
    n = 4;
    if (v.lng) begin
      c = 16'hFFFF;
      for (int i = 0; i < int'(v.word); i++) begin
        b = v.fen ? v.fill : pay_byte(v.src, i);
        exp_b[n] = b;
        n++;
        for (int j = 0; j < 8; j++) begin
          if (c[0] ^ b[j]) c = (c >> 1) ^ 16'h8408;
          else             c = c >> 1;
        end
      end
      exp_b[n]     = c[7:0];
      exp_b[n + 1] = c[15:8];
      n += 2;
    end
    return n;
  endfunction

  task automatic run_vec(input int vi);
    vec_t v;
    int   n_exp, nout, last_pos, cyc, pi, leak;
    bit   req_done, got_last, stall, pend, hold_ok, rdy;
    logic [7:0] prev_d;
    logic prev_l;
    string tag;
    v = VECS[vi];
    n_exp = build_exp(v);
    nout = 0; last_pos = -1; cyc = 0; pi = 0; leak = 0;
    req_done = 0; got_last = 0; stall = 0; pend = 0; hold_ok = 1;
    prev_d = '0; prev_l = 1'b0;
    while (!got_last && cyc < 2000) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      req_valid   = !req_done;
      req_dt      = v.dt;
      req_vc      = v.vc;
      req_long    = v.lng;
      req_fill_en = v.fen;
      req_word    = v.word;
      req_fill    = v.fill;
      case (v.bp)
        2'd0:    rdy = 1'b1;
        2'd1:    rdy = cyc[0];
        default: rdy = lf[0];
      endcase
      out_ready = rdy;
      if (v.fen) begin
        pay_valid = 1'b1;
        pay_data  = 8'hEE;
      end else begin
        pay_valid = pend || ((pi < int'(v.word)) && (v.bp == 2'd0 || (cyc % 3) != 1));
        pay_data  = pay_byte(v.src, pi);
      end
      #1;
      if (stall) begin
        if (!(out_valid && out_data == prev_d && out_last == prev_l)) hold_ok = 0;
      end
      if (req_valid && req_ready) req_done = 1;
      if (pay_valid && pay_ready) begin
        if (v.fen) leak++;
        pi++;
      end
      pend = pay_valid && !pay_ready && !v.fen;
      if (out_valid && out_ready) begin
        if (nout < 64) got_b[nout] = out_data;
        if (out_last) begin
          got_last = 1;
          last_pos = nout;
        end
        nout++;
      end
      stall  = out_valid && !out_ready;
      prev_d = out_data;
      prev_l = out_last;
      cyc++;
    end
    @(negedge clk);
    req_valid = 1'b0;
    pay_valid = 1'b0;
    out_ready = 1'b0;

    tag = !v.lng ? "R6" : (v.fen ? "R7" : ((v.word == 0) ? "R8" : "R2"));
    check(nout == n_exp, {tag, " length"}, nout, n_exp);
    for (int i = 0; i < 4; i++) begin
      if (got_b[i] != exp_b[i]) begin
        check(1'b0, "R1/R3 header byte", int'(got_b[i]), int'(exp_b[i]));
        break;
      end
    end
    check(1'b1, "R1 header", 0, 0);
    if (v.lng && nout == n_exp) begin
      int bad = -1;
      for (int i = 4; i < n_exp - 2; i++) if (bad < 0 && got_b[i] != exp_b[i]) bad = i;
      check(bad < 0, {tag, " payload"}, (bad < 0) ? 0 : int'(got_b[bad]), (bad < 0) ? 0 : int'(exp_b[bad]));
      check(got_b[n_exp-2] == exp_b[n_exp-2] && got_b[n_exp-1] == exp_b[n_exp-1], "R4/R5 crc bytes",
            int'({got_b[n_exp-1], got_b[n_exp-2]}), int'({exp_b[n_exp-1], exp_b[n_exp-2]}));
    end
    check(last_pos == n_exp - 1, v.lng ? "R5 last position" : "R6 last position", last_pos, n_exp - 1);
    check(hold_ok, "R9 hold under backpressure", 0, 1);
    if (v.fen) check(leak == 0, "R7 payload port ignored", leak, 0);
    if (vi == 0) check(got_b[3] == 8'h0A, "R3 known ecc", int'(got_b[3]), 8'h0A);
    if (vi == 2) check({got_b[14], got_b[13]} == 16'h6F91, "R4 known crc",
                       int'({got_b[14], got_b[13]}), 16'h6F91);
    if (vi == 5) check(got_b[4] == 8'hFF && got_b[5] == 8'hFF, "R8 empty crc",
                       int'({got_b[5], got_b[4]}), 16'hFFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_dt = '0; req_vc = '0; req_long = 0; req_fill_en = 0;
    req_word = '0; req_fill = '0; pay_valid = 0; pay_data = '0; out_ready = 0;
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && !pay_ready && !req_ready, "R10 reset state",
          int'({out_valid, pay_ready, req_ready}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(req_ready && !out_valid, "R10 ready after release", int'({req_ready, out_valid}), 2);

    for (int vi = 0; vi < NV; vi++) run_vec(vi);

    // Stall a packet, confirm no new request is taken, then reset mid-packet.
    @(negedge clk);
    req_valid = 1; req_dt = 6'h19; req_vc = 2'd0; req_long = 1; req_fill_en = 1;
    req_word = 16'd6; req_fill = 8'h00; out_ready = 0;
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    #1;
    check(!req_ready && out_valid && out_data == 8'h19, "R10 busy during packet",
          int'({req_ready, out_valid, out_data}), int'({1'b0, 1'b1, 8'h19}));
    rst_n = 1'b0;
    #1;
    check(!out_valid && !req_ready, "R10 mid-packet reset", int'({out_valid, req_ready}), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(req_ready && !out_valid, "R10 idle after reset", int'({req_ready, out_valid}), 2);
    run_vec(1);
    run_vec(6);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule